// File: doc/BRIEF.md
# Multi-channel PWM timer bank

The block is a bank of up to four pulse width modulator channels behind a small 32-bit register bus. Software sets each channel's high-phase and low-phase lengths in one packed reload word. It picks the count tick for the channel, either every bus clock cycle or a single-cycle enable pulse on `ext_tick_i`, and starts or stops the channel through a shared enable register. While a channel runs, its output repeats a high phase and then a low phase, and each phase lasts a programmed number of ticks.

A reload written while a channel runs does not disturb the period in progress. The channel picks up the new lengths at the next period start. Clearing the enable bit forces the output low at once. Register writes take effect at the clock edge that samples `wr_en_i`. A read issued with `rd_en_i` returns its data on `rdata_o` after that same edge, and `rdata_o` holds the value until the next read.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads 0 and every PWM output is low.
- R2: The register map places the shared enable register at byte offset 0x1C, where channel ch's enable is bit 3+4*ch. The control register of channel ch is at 0x20+0x10*ch and keeps bits [4:0]. The reload register of channel ch is at 0x24+0x10*ch and keeps all 32 bits. Every stored bit reads back.
- R3: Reads of unmapped offsets return 0 and writes to them change nothing. Bits [31:5] of a control register and the non-enable bits of the enable register read 0.
- R4: A channel runs only while its enable bit is 1 and its control bits [2:0] equal 3'b100. Otherwise its output is low.
- R5: A running channel drives its output high for (reload[31:16] + 1) ticks and then low for (reload[15:0] + 1) ticks, repeating. The longest phase is 65536 ticks.
- R6: Once a channel is allowed to run, it starts with the high phase on the next selected tick. With the bus-clock tick, the output rises one cycle after the enable write.
- R7: Control bit 3 selects the tick: 1 counts every bus clock cycle, and 0 counts only cycles with `ext_tick_i` high.
- R8: A reload write made while a channel runs lets the current period finish with the old lengths. The new lengths apply from the next period start.
- R9: A change of control bit 3 while a channel runs keeps the old tick source until the reload register is next written, and the new source applies after that write.
- R10: Clearing a channel's enable bit drives its output to 0 in the cycle after the write edge, without finishing the period.
- R11: Channels count independently, and each output follows only its own registers.
- R12: With both fields at 0 the output toggles every tick, so a running channel never holds a constant level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, updated the cycle after a read strobe |
| ext_tick_i | input | 1 | Synchronous external tick enable |
| pwm_o | output | N_CH | One PWM output per channel |

## Verification
The hardest cases to produce are those where a register write has to land inside a particular phase of a running waveform. One is a reload that must arrive mid-high so the period boundary rule shows. Another is a tick-source change that must stay pending across whole periods. The stimulus waits until the monitor has locked onto a rising output edge and issues the write a known number of cycles later. Lengths are chosen so that the write cannot reach the boundary. The scoreboard then expects the old phase lengths for the rest of that period and the new ones after it.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned PHASE_W   = 16;
  localparam int unsigned CTRL_W    = 5;
  localparam int unsigned SRC_BIT   = 3;
  localparam int unsigned EN_BASE   = 3;
  localparam int unsigned EN_STEP   = 4;
  localparam int unsigned EN_OFFS   = 32'h1C;
  localparam int unsigned CH_BASE   = 32'h20;
  localparam int unsigned CH_STRIDE = 32'h10;
  localparam int unsigned RELOAD_OFFS = 32'h4;
  localparam logic [2:0]  MODE_PWM  = 3'b100;

  typedef struct packed {
    logic [PHASE_W-1:0] hi;
    logic [PHASE_W-1:0] lo;
  } reload_t;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic                           rd_en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [N_CH-1:0]                en_o,
  output logic [N_CH-1:0][CTRL_W-1:0]    ctrl_o,
  output reload_t [N_CH-1:0]             reload_o,
  output logic [N_CH-1:0]                reload_wr_o
);
  localparam logic [ADDR_W-1:0] EnAddr = ADDR_W'(EN_OFFS);

  logic                        hit_en;
  logic [N_CH-1:0]             hit_ctrl, hit_rel;
  logic [N_CH-1:0]             en_q;
  logic [N_CH-1:0][CTRL_W-1:0] ctrl_q;
  reload_t [N_CH-1:0]          reload_q;
  logic [DATA_W-1:0]           rd_mux, rdata_q;

  assign hit_en = (addr_i == EnAddr);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CH_BASE + CH_STRIDE * c);
    localparam logic [ADDR_W-1:0] RelAddr  = ADDR_W'(CH_BASE + CH_STRIDE * c + RELOAD_OFFS);

    assign hit_ctrl[c]    = (addr_i == CtrlAddr);
    assign hit_rel[c]     = (addr_i == RelAddr);
    assign reload_wr_o[c] = wr_en_i && hit_rel[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[c]     <= 1'b0;
        ctrl_q[c]   <= '0;
        reload_q[c] <= '0;
      end else if (wr_en_i) begin
        if (hit_en)      en_q[c]     <= wdata_i[EN_BASE + EN_STEP * c];
        if (hit_ctrl[c]) ctrl_q[c]   <= wdata_i[CTRL_W-1:0];
        if (hit_rel[c])  reload_q[c] <= reload_t'(wdata_i);
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_en) begin
      for (int c = 0; c < N_CH; c++) rd_mux[EN_BASE + EN_STEP * c] = en_q[c];
    end
    for (int c = 0; c < N_CH; c++) begin
      if (hit_ctrl[c]) rd_mux = DATA_W'(ctrl_q[c]);
      if (hit_rel[c])  rd_mux = DATA_W'(reload_q[c]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign en_o     = en_q;
  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = PHASE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             src_bus_i,
  input  logic             ext_tick_i,
  input  logic             reload_wr_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             pwm_o
);
  logic             active_q, high_q, src_q, src_eff, tick;
  logic [CNT_W-1:0] cnt_q, lo_q;

  // source is latched while running; a reload write re-samples it
  assign src_eff = active_q ? src_q : src_bus_i;
  assign tick    = src_eff | ext_tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      src_q <= 1'b0;
    else if (!active_q || reload_wr_i) src_q <= src_bus_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      high_q   <= 1'b0;
      cnt_q    <= '0;
      lo_q     <= '0;
    end else if (!run_i) begin
      active_q <= 1'b0;
      high_q   <= 1'b0;
    end else if (tick) begin
      if (!active_q || (cnt_q == '0 && !high_q)) begin
        active_q <= 1'b1;
        high_q   <= 1'b1;
        cnt_q    <= hi_i;
        lo_q     <= lo_i;
      end else if (cnt_q == '0) begin
        high_q <= 1'b0;
        cnt_q  <= lo_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign pwm_o = run_i && active_q && high_q;
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              ext_tick_i,
  output logic [N_CH-1:0]   pwm_o
);
  logic [N_CH-1:0]             en_w, run_w, reload_wr_w;
  logic [N_CH-1:0][CTRL_W-1:0] ctrl_w;
  reload_t [N_CH-1:0]          reload_w;
  logic                        unused_ctrl;

  pwm_timer_regs #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .en_o        (en_w),
    .ctrl_o      (ctrl_w),
    .reload_o    (reload_w),
    .reload_wr_o (reload_wr_w)
  );

  assign unused_ctrl = ^ctrl_w;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign run_w[c] = en_w[c] && (ctrl_w[c][2:0] == MODE_PWM);

    pwm_timer_chan #(.CNT_W(PHASE_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run_w[c]),
      .src_bus_i   (ctrl_w[c][SRC_BIT]),
      .ext_tick_i  (ext_tick_i),
      .reload_wr_i (reload_wr_w[c]),
      .hi_i        (reload_w[c].hi),
      .lo_i        (reload_w[c].lo),
      .pwm_o       (pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic [N_CH-1:0]   pwm_o,
  input logic [N_CH-1:0]   en_i,
  input logic [N_CH-1:0]   run_i
);
  logic mapped;

  always_comb begin
    mapped = (addr_i == ADDR_W'(EN_OFFS));
    for (int c = 0; c < N_CH; c++) begin
      if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * c) ||
          addr_i == ADDR_W'(CH_BASE + CH_STRIDE * c + RELOAD_OFFS)) mapped = 1'b1;
    end
  end

  a_r3_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !mapped |=> rdata_o == 32'h0);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    a_r10_disable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(en_i[c]) |-> !pwm_o[c]);

    a_r4_out_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwm_o[c] |-> run_i[c]);

    a_r2_enable_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i && !wr_en_i && addr_i == ADDR_W'(EN_OFFS)
      |=> rdata_o[EN_BASE + EN_STEP * c] == $past(en_i[c]));
  end
endmodule

bind pwm_timer_bank pwm_timer_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .pwm_o   (pwm_o),
  .en_i    (en_w),
  .run_i   (run_w)
);

// File: tb/tb_pwm_timer_bank.sv
`timescale 1ns/1ps
module tb_pwm_timer_bank;
  localparam int N_CH = 4;
  localparam int ADDR_W = 8;

  typedef struct {
    bit    lvl;
    int    len;
    string req;
  } run_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0, ext_tick = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [N_CH-1:0]   pwm;

  int   checks = 0, errors = 0;
  bit   done = 0;
  run_t exp_q[$];
  bit   mon_on = 0, armed = 0, prev = 0, tick_on = 0;
  int   mon_ch = 0, run_len = 0, tick_cnt = 0;

  always #2 clk = ~clk;

  pwm_timer_bank #(.N_CH(N_CH), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ext_tick_i(ext_tick), .pwm_o(pwm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    check(rdata === exp, req, rdata, exp);
  endtask

  task automatic push(input bit l, input int n, input string req);
    run_t it;
    it.lvl = l; it.len = n; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic hold_low(input int ch, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(pwm[ch] === 1'b0, req, pwm[ch], 0);
    end
  endtask

  // external tick: one pulse every third cycle
  always @(negedge clk) begin
    if (tick_on) begin
      ext_tick <= (tick_cnt == 0);
      tick_cnt <= (tick_cnt == 2) ? 0 : tick_cnt + 1;
    end else begin
      ext_tick <= 1'b0;
      tick_cnt <= 0;
    end
  end

  // monitor: measures run lengths after the first rising edge and scores them
  always @(negedge clk) begin
    bit l;
    l = pwm[mon_ch];
    if (!mon_on) begin
      armed = 0;
    end else if (!armed) begin
      if (l && !prev) begin armed = 1; run_len = 1; end
    end else if (l == prev) begin
      run_len++;
    end else begin
      if (exp_q.size() != 0) begin
        run_t it;
        it = exp_q.pop_front();
        check(it.lvl == prev && it.len == run_len, it.req, run_len, it.len);
      end
      run_len = 1;
    end
    prev = l;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(pwm === 4'b0, "R1 outputs", pwm, 0);
    bus_rd(8'h1C, 32'h0, "R1 enable");
    bus_rd(8'h20, 32'h0, "R1 ctrl0");
    bus_rd(8'h54, 32'h0, "R1 reload3");

    // R2 / R3 register map and readback
    bus_wr(8'h24, 32'hDEAD_BEEF);
    bus_rd(8'h24, 32'hDEAD_BEEF, "R2 reload0");
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd(8'h20, 32'h0000_001F, "R3 ctrl upper bits");
    bus_wr(8'h1C, 32'hFFFF_FFFF);
    bus_rd(8'h1C, 32'h0000_8888, "R2 enable bits");
    hold_low(0, 4, "R4 non-pwm mode stays low");
    check(pwm === 4'b0, "R4 all low", pwm, 0);
    bus_wr(8'h10, 32'h1234_5678);
    bus_rd(8'h10, 32'h0, "R3 unmapped 0x10");
    bus_wr(8'h28, 32'h5555_5555);
    bus_rd(8'h28, 32'h0, "R3 unmapped 0x28");
    bus_rd(8'h24, 32'hDEAD_BEEF, "R3 write ignored");
    bus_wr(8'h1C, 32'h0);

    // R6 start timing, R5 phase lengths on bus clock
    bus_wr(8'h20, 32'h0C);
    bus_wr(8'h24, {16'd5, 16'd4});
    bus_wr(8'h1C, 32'h8);
    check(pwm[0] === 1'b0, "R6 not yet high", pwm[0], 0);
    @(negedge clk);
    check(pwm[0] === 1'b1, "R6 high one cycle later", pwm[0], 1);
    mon_on = 1;
    push(1, 6, "R5 high 5+1"); push(0, 5, "R5 low 4+1");

    // R8 reload mid-period
    push(1, 6, "R8 old high kept"); push(0, 5, "R8 old low kept");
    push(1, 2, "R8 new high");      push(0, 2, "R8 new low");
    push(1, 2, "R8 new high again");
    while (exp_q.size() != 5) @(negedge clk);
    while (!pwm[0]) @(negedge clk);
    bus_wr(8'h24, {16'd1, 16'd1});
    drain();
    mon_on = 0;

    // R12 minimum lengths
    bus_wr(8'h1C, 32'h0);
    bus_wr(8'h24, 32'h0);
    mon_on = 1;
    push(1, 1, "R12 high 1"); push(0, 1, "R12 low 1");
    push(1, 1, "R12 high 1"); push(0, 1, "R12 low 1");
    bus_wr(8'h1C, 32'h8);
    drain();
    mon_on = 0;

    // R5 longest phase
    bus_wr(8'h1C, 32'h0);
    bus_wr(8'h24, {16'hFFFF, 16'h0});
    mon_on = 1;
    push(1, 65536, "R5 high 65536"); push(0, 1, "R5 low 1");
    bus_wr(8'h1C, 32'h8);
    drain();
    mon_on = 0;

    // R10 disable mid-high
    bus_wr(8'h1C, 32'h0);
    bus_wr(8'h24, {16'd99, 16'd3});
    bus_wr(8'h1C, 32'h8);
    while (!pwm[0]) @(negedge clk);
    repeat (3) @(negedge clk);
    bus_wr(8'h1C, 32'h0);
    check(pwm[0] === 1'b0, "R10 low right after write", pwm[0], 0);
    hold_low(0, 20, "R10 stays low");

    // R7 external tick
    bus_wr(8'h20, 32'h04);
    bus_wr(8'h24, {16'd1, 16'd0});
    tick_on = 1;
    mon_on = 1;
    push(1, 6, "R7 ext high 2 ticks"); push(0, 3, "R7 ext low 1 tick");
    push(1, 6, "R7 ext high");         push(0, 3, "R7 ext low");
    bus_wr(8'h1C, 32'h8);
    drain();

    // R9 source change pending until reload write
    bus_wr(8'h20, 32'h0C);
    push(1, 6, "R9 old source kept"); push(0, 3, "R9 old source low");
    push(1, 6, "R9 old source kept"); push(0, 3, "R9 old source low");
    drain();
    mon_on = 0;
    bus_wr(8'h24, {16'd1, 16'd0});
    repeat (10) @(negedge clk);
    mon_on = 1;
    push(1, 2, "R9 new source high"); push(0, 1, "R9 new source low");
    push(1, 2, "R9 new source high"); push(0, 1, "R9 new source low");
    drain();
    mon_on = 0;
    tick_on = 0;

    // R11 independent channels
    bus_wr(8'h1C, 32'h0);
    bus_wr(8'h24, 32'h0);
    bus_wr(8'h50, 32'h0C);
    bus_wr(8'h54, {16'd1, 16'd2});
    mon_ch = 3;
    mon_on = 1;
    push(1, 2, "R11 ch3 high"); push(0, 3, "R11 ch3 low");
    push(1, 2, "R11 ch3 high"); push(0, 3, "R11 ch3 low");
    bus_wr(8'h1C, 32'h8008);
    drain();
    check(pwm[2:1] === 2'b00, "R11 idle channels low", pwm[2:1], 0);
    mon_on = 0;

    // R4 mode field gates the channel
    bus_wr(8'h20, 32'h08);
    hold_low(0, 10, "R4 mode 0 low");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule